// File: doc/BRIEF.md
# TDM Serial Audio Master Transmitter

This block drives a time-division multiplexed serial audio line as the bus master. An external bit-clock enable tick paces it. On each tick it emits one data bit and updates the frame-sync line. A frame holds a programmable number of slots, and each slot holds a programmable number of bit periods. A slot-enable mask decides which slots carry samples.

Parallel samples arrive on a valid/ready stream. One sample is taken at the first bit of every enabled slot and sent MSB first, left justified. The word length is 8, 16, 24 or 32 bits. Any bit periods after the word are driven low. The frame-sync pulse is placed by two programmable coordinates, a start and an end, each given as a (slot, bit) pair. This lets one block produce both a sync that leads the first data bit by one clock and a one-clock sync on the first data bit. A mute control replaces every sample with a constant. An underrun option picks what is sent when no sample is waiting.

Top module: `tdm_tx_master`

## Requirements
- R1: While enabled, each tick advances a bit counter from 0 to `bit_max_i`, then wraps it to 0 and advances a slot counter from 0 to `slot_max_i`. While disabled, both counters are held at (slot 0, bit 0), so the first tick after enable is slot 0, bit 0.
- R2: On a tick at the start coordinate, the internal sync goes high from that edge on. On a tick at the end coordinate, it goes low. If both coordinates match, start wins. With the start at (last slot, last bit) and the end at (0, 0), the sync leads the first data bit by one clock. With the start at (0, 0) and the end at (0, 1), the sync is a one-clock pulse on the first data bit.
- R3: `fs_o` equals the internal sync XOR `fs_inv_i`.
- R4: `word_size_i` selects the word length: 00 = 8, 01 = 16, 10 = 24, 11 = 32 bits. The sample sits in the low bits of `sample_i`; higher bits are ignored. Its bits are driven MSB first, starting at bit 0 of the slot. `sd_o` changes only at a clock edge that carries a tick.
- R5: Bit periods of a slot at or beyond the word length drive `sd_o` low.
- R6: Bit n of `slot_mask_i` enables slot n. A disabled slot drives `sd_o` low for the whole slot and takes no sample.
- R7: `sample_ready_o` is high exactly in a cycle with the block enabled, a tick present, the bit counter at 0 and the current slot enabled. A sample is consumed when valid and ready are both high.
- R8: With `mute_i` high, every enabled slot sends `mute_word_i` (low bits, same alignment as a sample). Samples are still consumed.
- R9: If an enabled slot starts with no valid sample and without mute, it sends `mute_word_i` when `underrun_mute_i` is 1 and zeros when it is 0.
- R10: With `en_i` low, from the next clock on `sd_o` is 0, the internal sync is low (so `fs_o` equals `fs_inv_i`) and `sample_ready_o` is 0. The same holds during reset.
- R11: In cycles without a tick, `sd_o` and `fs_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmitter enable |
| bclk_en_i | input | 1 | Bit-clock tick, one cycle per bit period |
| sample_i | input | 32 | Sample, right aligned |
| sample_valid_i | input | 1 | Sample valid |
| sample_ready_o | output | 1 | Sample taken this cycle |
| mute_i | input | 1 | Send mute word in all enabled slots |
| mute_word_i | input | 32 | Mute constant, right aligned |
| underrun_mute_i | input | 1 | On underrun send mute word (1) or zeros (0) |
| word_size_i | input | 2 | Word length code |
| slot_max_i | input | SLOT_W | Slots per frame minus one |
| bit_max_i | input | BIT_W | Bit periods per slot minus one |
| slot_mask_i | input | MAX_SLOTS | Slot enable mask |
| fs_start_slot_i | input | SLOT_W | Sync start slot |
| fs_start_bit_i | input | BIT_W | Sync start bit |
| fs_end_slot_i | input | SLOT_W | Sync end slot |
| fs_end_bit_i | input | BIT_W | Sync end bit |
| fs_inv_i | input | 1 | Invert frame sync |
| fs_o | output | 1 | Frame sync |
| sd_o | output | 1 | Serial data |

## Verification
The bench builds the block with its default 16 slots and 32 bit periods per slot. With these values, 32-bit words filling whole slots are reachable, as are 8- and 24-bit words followed by long runs of trailing zero bits. Frames with sparse masks across many slots can be tested, and both sync placements can be checked at the slot and bit wrap points. Random rounds draw slot counts up to eight to keep runs short. Directed cases cover the full-width word, mute, underrun and a restart in the middle of a frame.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    WS_8  = 2'b00,
    WS_16 = 2'b01,
    WS_24 = 2'b10,
    WS_32 = 2'b11
  } word_size_e;

  // move the right-aligned word so its MSB sits at WORD_W-1
  function automatic logic [WORD_W-1:0] left_align(input logic [WORD_W-1:0] w,
                                                   input word_size_e ws);
    case (ws)
      WS_8:    return w << 24;
      WS_16:   return w << 16;
      WS_24:   return w << 8;
      default: return w;
    endcase
  endfunction
endpackage

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter #(
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned BIT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [SLOT_W-1:0] slot_max_i,
  input  logic [BIT_W-1:0]  bit_max_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIT_W-1:0]  bit_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      bit_q  <= '0;
    end else if (!en_i) begin
      slot_q <= '0;
      bit_q  <= '0;
    end else if (tick_i) begin
      if (bit_q >= bit_max_i) begin
        bit_q  <= '0;
        slot_q <= (slot_q >= slot_max_i) ? '0 : slot_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign slot_o = slot_q;
  assign bit_o  = bit_q;
endmodule

// File: rtl/tdm_fsync_gen.sv
module tdm_fsync_gen #(
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned BIT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [SLOT_W-1:0] start_slot_i,
  input  logic [BIT_W-1:0]  start_bit_i,
  input  logic [SLOT_W-1:0] end_slot_i,
  input  logic [BIT_W-1:0]  end_bit_i,
  output logic              fs_o
);
  logic fs_q;
  logic at_start, at_end;

  assign at_start = (slot_i == start_slot_i) && (bit_i == start_bit_i);
  assign at_end   = (slot_i == end_slot_i)   && (bit_i == end_bit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          fs_q <= 1'b0;
    else if (!en_i)       fs_q <= 1'b0;
    else if (tick_i) begin
      if (at_start)       fs_q <= 1'b1;  // start has priority
      else if (at_end)    fs_q <= 1'b0;
    end
  end

  assign fs_o = fs_q;
endmodule

// File: rtl/tdm_word_shifter.sv
module tdm_word_shifter
  import tdm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  word_size_e        ws_i,
  output logic              sd_o
);
  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] aligned;
  logic              sd_q;

  assign aligned = left_align(word_i, ws_i);

  // zeros shift in behind the word, so trailing bits go low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      sd_q    <= 1'b0;
    end else if (!en_i) begin
      shreg_q <= '0;
      sd_q    <= 1'b0;
    end else if (tick_i) begin
      if (load_i) begin
        sd_q    <= aligned[WORD_W-1];
        shreg_q <= aligned << 1;
      end else begin
        sd_q    <= shreg_q[WORD_W-1];
        shreg_q <= shreg_q << 1;
      end
    end
  end

  assign sd_o = sd_q;
endmodule

// File: rtl/tdm_tx_master.sv
module tdm_tx_master
  import tdm_pkg::*;
#(
  parameter int unsigned MAX_SLOTS = 16,
  parameter int unsigned MAX_BITS  = 32,
  localparam int unsigned SLOT_W   = $clog2(MAX_SLOTS),
  localparam int unsigned BIT_W    = $clog2(MAX_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 bclk_en_i,
  input  logic [WORD_W-1:0]    sample_i,
  input  logic                 sample_valid_i,
  output logic                 sample_ready_o,
  input  logic                 mute_i,
  input  logic [WORD_W-1:0]    mute_word_i,
  input  logic                 underrun_mute_i,
  input  logic [1:0]           word_size_i,
  input  logic [SLOT_W-1:0]    slot_max_i,
  input  logic [BIT_W-1:0]     bit_max_i,
  input  logic [MAX_SLOTS-1:0] slot_mask_i,
  input  logic [SLOT_W-1:0]    fs_start_slot_i,
  input  logic [BIT_W-1:0]     fs_start_bit_i,
  input  logic [SLOT_W-1:0]    fs_end_slot_i,
  input  logic [BIT_W-1:0]     fs_end_bit_i,
  input  logic                 fs_inv_i,
  output logic                 fs_o,
  output logic                 sd_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  bit_q;
  logic              fs_raw;
  logic              slot_on;
  logic              slot_head;
  logic [WORD_W-1:0] word_sel;

  tdm_frame_counter #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .tick_i     (bclk_en_i),
    .slot_max_i (slot_max_i),
    .bit_max_i  (bit_max_i),
    .slot_o     (slot_q),
    .bit_o      (bit_q)
  );

  tdm_fsync_gen #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_fs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .tick_i       (bclk_en_i),
    .slot_i       (slot_q),
    .bit_i        (bit_q),
    .start_slot_i (fs_start_slot_i),
    .start_bit_i  (fs_start_bit_i),
    .end_slot_i   (fs_end_slot_i),
    .end_bit_i    (fs_end_bit_i),
    .fs_o         (fs_raw)
  );

  assign slot_on   = slot_mask_i[slot_q];
  assign slot_head = (bit_q == '0);

  always_comb begin
    if (!slot_on)            word_sel = '0;
    else if (mute_i)         word_sel = mute_word_i;
    else if (sample_valid_i) word_sel = sample_i;
    else if (underrun_mute_i) word_sel = mute_word_i;
    else                     word_sel = '0;
  end

  // muted slots still drain the stream to keep slot alignment
  assign sample_ready_o = en_i && bclk_en_i && slot_head && slot_on;

  tdm_word_shifter u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_i (bclk_en_i),
    .load_i (slot_head),
    .word_i (word_sel),
    .ws_i   (word_size_e'(word_size_i)),
    .sd_o   (sd_o)
  );

  assign fs_o = fs_raw ^ fs_inv_i;
endmodule

// File: rtl/tdm_tx_checker.sv
module tdm_tx_checker #(
  parameter int unsigned MAX_SLOTS = 16,
  parameter int unsigned SLOT_W    = 4,
  parameter int unsigned BIT_W     = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 en_i,
  input logic                 bclk_en_i,
  input logic [MAX_SLOTS-1:0] slot_mask_i,
  input logic [BIT_W-1:0]     bit_max_i,
  input logic [SLOT_W-1:0]    fs_start_slot_i,
  input logic [BIT_W-1:0]     fs_start_bit_i,
  input logic [SLOT_W-1:0]    fs_end_slot_i,
  input logic [BIT_W-1:0]     fs_end_bit_i,
  input logic [SLOT_W-1:0]    slot_q,
  input logic [BIT_W-1:0]     bit_q,
  input logic                 fs_q,
  input logic                 sd_o,
  input logic                 sample_ready_o
);
  assert_bit_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && bclk_en_i && (bit_q < bit_max_i) |=> bit_q == BIT_W'($past(bit_q) + 1'b1));

  assert_fs_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && bclk_en_i && slot_q == fs_start_slot_i && bit_q == fs_start_bit_i |=> fs_q);

  assert_fs_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && bclk_en_i && slot_q == fs_end_slot_i && bit_q == fs_end_bit_i &&
    !(slot_q == fs_start_slot_i && bit_q == fs_start_bit_i) |=> !fs_q);

  assert_off_slot_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && bclk_en_i && bit_q == '0 && !slot_mask_i[slot_q] |=> !sd_o);

  assert_ready_at_head_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_ready_o |-> bit_q == '0);

  assert_idle_when_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sd_o && !fs_q && slot_q == '0 && bit_q == '0);

  assert_hold_no_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !bclk_en_i |=> $stable(sd_o) && $stable(fs_q));
endmodule

bind tdm_tx_master tdm_tx_checker #(
  .MAX_SLOTS (MAX_SLOTS),
  .SLOT_W    (SLOT_W),
  .BIT_W     (BIT_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .en_i            (en_i),
  .bclk_en_i       (bclk_en_i),
  .slot_mask_i     (slot_mask_i),
  .bit_max_i       (bit_max_i),
  .fs_start_slot_i (fs_start_slot_i),
  .fs_start_bit_i  (fs_start_bit_i),
  .fs_end_slot_i   (fs_end_slot_i),
  .fs_end_bit_i    (fs_end_bit_i),
  .slot_q          (slot_q),
  .bit_q           (bit_q),
  .fs_q            (fs_raw),
  .sd_o            (sd_o),
  .sample_ready_o  (sample_ready_o)
);

// File: tb/tb_tdm_tx_master.sv
module tb_tdm_tx_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        bclk_en;
  logic [31:0] sample;
  logic        sample_valid;
  logic        sample_ready;
  logic        mute;
  logic [31:0] mute_word;
  logic        um;
  logic [1:0]  ws;
  logic [3:0]  slot_max;
  logic [4:0]  bit_max;
  logic [15:0] mask;
  logic [3:0]  ss, es;
  logic [4:0]  sb, eb;
  logic        inv;
  logic        fs_o, sd_o;

  always #10 clk = ~clk;

  tdm_tx_master #(.MAX_SLOTS(16), .MAX_BITS(32)) dut (
    .clk_i (clk), .rst_ni (rst_n), .en_i (en), .bclk_en_i (bclk_en),
    .sample_i (sample), .sample_valid_i (sample_valid), .sample_ready_o (sample_ready),
    .mute_i (mute), .mute_word_i (mute_word), .underrun_mute_i (um),
    .word_size_i (ws), .slot_max_i (slot_max), .bit_max_i (bit_max),
    .slot_mask_i (mask), .fs_start_slot_i (ss), .fs_start_bit_i (sb),
    .fs_end_slot_i (es), .fs_end_bit_i (eb), .fs_inv_i (inv),
    .fs_o (fs_o), .sd_o (sd_o)
  );

  int n_tests = 0, n_fail = 0;
  int m_slot, m_bit, vprob;
  logic m_fs, last_sd;
  logic [31:0] m_shift;
  string m_tag;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] align_ref(input logic [31:0] w, input logic [1:0] s);
    int wl = 8 * (int'(s) + 1);
    return w << (32 - wl);
  endfunction

  task automatic new_sample();
    sample       = $urandom;
    sample_valid = ($urandom_range(99) < vprob);
  endtask

  task automatic model_clear();
    m_slot = 0; m_bit = 0; m_fs = 1'b0; m_shift = '0; last_sd = 1'b0;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    chk(sd_o === last_sd, "R11", "sd hold", sd_o, last_sd);
    chk(fs_o === (m_fs ^ inv), "R11", "fs hold", fs_o, m_fs ^ inv);
  endtask

  task automatic do_tick(input string fs_tag);
    logic exp_rdy, exp_sd;
    logic [31:0] w;
    int wl;
    bit hs;
    string sd_tag;
    @(negedge clk);
    bclk_en = 1'b1;
    #1;
    wl = 8 * (int'(ws) + 1);
    exp_rdy = (m_bit == 0) && mask[m_slot];
    chk(sample_ready === exp_rdy, "R7", "ready", sample_ready, exp_rdy);
    hs = exp_rdy && sample_valid;
    if (m_bit == 0) begin
      if (!mask[m_slot])     begin w = '0;        m_tag = "R6"; end
      else if (mute)         begin w = mute_word; m_tag = "R8"; end
      else if (sample_valid) begin w = sample;    m_tag = "R4"; end
      else                   begin w = um ? mute_word : '0; m_tag = "R9"; end
      m_shift = align_ref(w, ws);
    end
    exp_sd  = m_shift[31];
    m_shift = m_shift << 1;
    sd_tag  = !mask[m_slot] ? "R6" : (m_bit >= wl ? "R5" : m_tag);
    if (m_slot == int'(ss) && m_bit == int'(sb))      m_fs = 1'b1;
    else if (m_slot == int'(es) && m_bit == int'(eb)) m_fs = 1'b0;
    if (m_bit >= int'(bit_max)) begin
      m_bit = 0;
      m_slot = (m_slot >= int'(slot_max)) ? 0 : m_slot + 1;
    end else m_bit++;
    @(negedge clk);
    bclk_en = 1'b0;
    chk(sd_o === exp_sd, sd_tag, "sd", sd_o, exp_sd);
    chk(fs_o === (m_fs ^ inv), fs_tag, "fs", fs_o, m_fs ^ inv);
    last_sd = exp_sd;
    if (hs || !sample_valid) new_sample();
  endtask

  task automatic run_frames(input int frames, input string fs_tag);
    int n = frames * (int'(slot_max) + 1) * (int'(bit_max) + 1);
    for (int i = 0; i < n; i++) begin
      int gap = $urandom_range(2);
      for (int g = 0; g < gap; g++) idle_cycle();
      do_tick(fs_tag);
    end
  endtask

  task automatic go_off();
    @(negedge clk);
    en = 1'b0;
    bclk_en = 1'b1;
    #1;
    chk(sample_ready === 1'b0, "R10", "ready off", sample_ready, 0);
    @(negedge clk);
    bclk_en = 1'b0;
    chk(sd_o === 1'b0, "R10", "sd off", sd_o, 0);
    chk(fs_o === inv, "R10", "fs off", fs_o, inv);
    model_clear();
  endtask

  task automatic go_on();
    @(negedge clk);
    en = 1'b1;
  endtask

  // fmt 0: sync one clock ahead; fmt 1: sync on first bit
  task automatic place_fs(input bit fmt);
    if (!fmt) begin ss = slot_max; sb = bit_max; es = '0; eb = '0; end
    else      begin ss = '0; sb = '0; es = '0; eb = 5'd1; end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; en = 1'b0; bclk_en = 1'b0; vprob = 85;
    mute = 1'b0; mute_word = 32'hA5C3_9E71; um = 1'b0; inv = 1'b0;
    ws = 2'b01; slot_max = 4'd3; bit_max = 5'd15; mask = 16'hF;
    place_fs(1'b1);
    new_sample();
    model_clear();
    repeat (3) @(negedge clk);
    chk(sd_o === 1'b0, "R10", "reset sd", sd_o, 0);
    chk(fs_o === 1'b0, "R10", "reset fs", fs_o, 0);
    chk(sample_ready === 1'b0, "R10", "reset ready", sample_ready, 0);
    rst_n = 1'b1;

    // one-clock sync on first bit, 16-bit full slots
    go_on();
    run_frames(3, "R2");
    // early sync, 24-bit in 32-bit slots, sparse mask
    go_off();
    ws = 2'b10; slot_max = 4'd2; bit_max = 5'd31; mask = 16'b101; place_fs(1'b0);
    go_on();
    run_frames(2, "R2");
    // mute, full 32-bit words, inverted sync
    go_off();
    ws = 2'b11; slot_max = 4'd1; bit_max = 5'd31; mask = 16'h3; mute = 1'b1; inv = 1'b1;
    place_fs(1'b1);
    go_on();
    run_frames(2, "R3");
    // underrun both ways, 8-bit words
    go_off();
    mute = 1'b0; inv = 1'b0; vprob = 0; new_sample();
    ws = 2'b00; slot_max = 4'd3; bit_max = 5'd9; mask = 16'b1011; um = 1'b1;
    place_fs(1'b0);
    go_on();
    run_frames(2, "R2");
    go_off();
    um = 1'b0;
    go_on();
    run_frames(2, "R2");
    // restart mid-frame: first tick must be slot 0 bit 0
    go_off();
    vprob = 85; new_sample(); place_fs(1'b1);
    go_on();
    for (int i = 0; i < 13; i++) do_tick("R2");
    go_off();
    go_on();
    do_tick("R1");
    run_frames(1, "R1");
    // random rounds
    for (int r = 0; r < 10; r++) begin
      go_off();
      ws       = 2'($urandom_range(3));
      bit_max  = 5'(8 * (int'(ws) + 1) - 1 + $urandom_range(31 - 8 * (int'(ws) + 1) + 1));
      slot_max = 4'($urandom_range(7));
      mask     = 16'($urandom) | 16'h1;
      mute     = ($urandom_range(3) == 0);
      um       = $urandom_range(1);
      inv      = $urandom_range(1);
      vprob    = $urandom_range(50, 100);
      mute_word = $urandom;
      place_fs($urandom_range(1));
      new_sample();
      go_on();
      run_frames(2, inv ? "R3" : "R2");
    end
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule